// File: doc/BRIEF.md
# Turbo Encoder Output Sequencer

This block is the datapath and sequencer of a rate-1/3 turbo encoder built from two identical recursive systematic convolutional encoders. A host moves one block of information bits in through a serial handshake. The block stores the bits and runs the encoding pass, taking the permuted bit stream for the second encoder from an external interleaver port. It then hands the coded stream back through a second serial handshake. The coded stream holds the data bits with their parity bits, followed by twelve termination bits that drive both encoders back to the all-zero state.

A mode input selects the full rate-1/3 stream or a built-in rate-1/2 stream. At rate 1/2 the two parity streams alternate. Two status outputs tell the host when the block accepts input and when coded output is ready. A synchronous abort returns the block to input from any phase. A request line for starting the external interleaver is forwarded only when no data bit of the current block has been taken yet.

Top module: `turbo_enc_seq`

## Requirements
- R1: While `inRdy` is high, each rising edge with `shiftInEn` high stores `dataIn` as the next information bit. An edge with `shiftInEn` low stores nothing and the stream resumes where it stopped.
- R2: The edge that stores bit number `blkSize` (legal range 40 to 5114) drops `inRdy`. In the next `blkSize` cycles `ilvReq` is high and `ilvIdx` counts 0, 1, … `blkSize`-1, and `ilvBit` is sampled in the same cycle. One further cycle follows, so `outRdy` rises `blkSize`+1 edges after the last input edge.
- R3: `shiftInEn` and `dataIn` have no effect while `inRdy` is low. Extra bits offered after the block is full do not appear in the coded output.
- R4: Each encoder starts at zero and uses feedback 1+D^2+D^3 and feedforward 1+D+D^3. The first encoder reads the stored bits in input order. The second encoder reads `ilvBit`.
- R5: With rate-1/2 mode off, each information bit k yields three output bits in the order systematic, parity of the first encoder, parity of the second encoder.
- R6: With rate-1/2 mode on, each bit k yields its systematic bit and then one parity bit. That parity comes from the first encoder for even k and from the second encoder for odd k, with k counted from 0.
- R7: After the data come 12 tail bits: systematic and parity pairs three times from the first encoder, then three pairs from the second. Each tail systematic bit is the encoder's feedback value, so the state returns to zero. The tail is the same in both modes.
- R8: While `outRdy` is high, an edge with `shiftOutEn` high loads the next coded bit into `dataOut`. An edge with `shiftOutEn` low leaves `dataOut` unchanged.
- R9: The edge that loads the last coded bit drops `outRdy`. The next edge clears `dataOut` and raises `inRdy`.
- R10: `ilvInitGo` is high for one cycle after an edge where `ilvInitReq` was high, `inRdy` was high and no bit of the block had been stored. Otherwise it stays low.
- R11: An asynchronous low on `rstN`, or an edge with `abortReq` high, leaves `inRdy` high, `outRdy`, `ilvReq` and `dataOut` low, and the block ready for a new block.
- R12: `blkSize` and `punctureEn` are sampled on the edge that stores the last information bit. Later changes do not affect that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| abortReq | input | 1 | Synchronous abort to the input phase |
| blkSize | input | 13 | Number of information bits in the block |
| punctureEn | input | 1 | 1 selects the rate-1/2 output stream |
| ilvInitReq | input | 1 | Request to start the external interleaver |
| shiftInEn | input | 1 | Input strobe |
| dataIn | input | 1 | Serial information bit |
| ilvBit | input | 1 | Interleaved information bit for position `ilvIdx` |
| shiftOutEn | input | 1 | Output strobe |
| inRdy | output | 1 | High while the block accepts information bits |
| outRdy | output | 1 | High while coded bits can be read |
| dataOut | output | 1 | Registered coded bit |
| ilvReq | output | 1 | High while the encoding pass reads `ilvBit` |
| ilvIdx | output | 13 | Position whose interleaved bit is needed |
| ilvInitGo | output | 1 | Accepted interleaver start pulse |

## Verification
Each result has a fixed due cycle. A stored input bit and an accepted init request show up one edge after the strobe. `ilvReq` rises on the edge that stores the last bit. `outRdy` rises `blkSize`+1 edges later, each coded bit appears one edge after its enabled strobe, and `inRdy` returns one edge after `outRdy` falls. The bench drives on the falling edge and compares at the next falling edge against a queue-based reference encoder. It also counts the encoding-pass cycles and the `ilvIdx` steps, so a result one cycle early or late is reported.

// File: rtl/turbo_seq_pkg.sv
package turbo_seq_pkg;

  typedef enum logic [2:0] {
    PH_LOAD,
    PH_ENCODE,
    PH_TERM,
    PH_UNLOAD,
    PH_FLUSH
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       capture;
    logic       encStep;
    logic       termLatch;
    logic       emit;
    logic       emitTail;
    logic [1:0] emitSel;
    logic [3:0] tailSel;
    logic       clear;
  } seqStrobe_t;

  localparam int TAIL_BITS = 12;

  // three flushing steps; bit i is the i-th transmitted tail bit
  // state bit 0 is the newest delay element
  function automatic logic [5:0] flushBits(input logic [2:0] st);
    logic [2:0] r;
    logic [5:0] o;
    r = st;
    o = '0;
    for (int i = 0; i < 3; i++) begin
      o[2*i]   = r[1] ^ r[2];
      o[2*i+1] = r[0] ^ r[2];
      r = {r[1], r[0], 1'b0};
    end
    return o;
  endfunction

endpackage

// File: rtl/rsc_enc.sv
module rsc_enc (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       step,
  input  logic       u,
  output logic       parity,
  output logic [2:0] state
);
  logic fb;

  always_comb begin
    fb     = u ^ state[1] ^ state[2];
    parity = fb ^ state[0] ^ state[2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      state <= '0;
    else if (clear) state <= '0;
    else if (step)  state <= {state[1], state[0], fb};
  end
endmodule

// File: rtl/turbo_seq_dp.sv
module turbo_seq_dp
  import turbo_seq_pkg::*;
#(
  parameter int MAX_BLK = 5114,
  parameter int SIZE_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [SIZE_W-1:0] addr,
  input  logic              dataIn,
  input  logic              ilvBit,
  output logic              dataOut
);
  localparam int AW = $clog2(MAX_BLK);

  // word layout: bit 0 systematic, bit 1 parity 1, bit 2 parity 2
  logic [2:0]          mem [MAX_BLK];
  logic [AW-1:0]       memIdx;
  logic [2:0]          rdWord;
  logic [1:0]          encIn;
  logic [1:0]          par;
  logic [2:0]          encState [2];
  logic [TAIL_BITS-1:0] tailReg;

  assign memIdx = addr[AW-1:0];
  assign rdWord = mem[memIdx];
  assign encIn  = {ilvBit, rdWord[0]};

  for (genvar g = 0; g < 2; g++) begin : gEnc
    rsc_enc uEnc (
      .clk   (clk),
      .rstN  (rstN),
      .clear (stb.clear),
      .step  (stb.encStep),
      .u     (encIn[g]),
      .parity(par[g]),
      .state (encState[g])
    );
  end

  always_ff @(posedge clk) begin
    if (stb.capture)      mem[memIdx] <= {2'b00, dataIn};
    else if (stb.encStep) mem[memIdx][2:1] <= {par[1], par[0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailReg <= '0;
      dataOut <= 1'b0;
    end else if (stb.clear) begin
      tailReg <= '0;
      dataOut <= 1'b0;
    end else begin
      if (stb.termLatch)
        tailReg <= {flushBits(encState[1]), flushBits(encState[0])};
      if (stb.emit)
        dataOut <= stb.emitTail ? tailReg[stb.tailSel] : rdWord[stb.emitSel];
    end
  end
endmodule

// File: rtl/turbo_seq_ctl.sv
module turbo_seq_ctl
  import turbo_seq_pkg::*;
#(
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abortReq,
  input  logic [SIZE_W-1:0] blkSize,
  input  logic              punctureEn,
  input  logic              ilvInitReq,
  input  logic              shiftInEn,
  input  logic              shiftOutEn,
  output seqStrobe_t        stb,
  output logic [SIZE_W-1:0] addr,
  output logic              inRdy,
  output logic              outRdy,
  output logic              ilvReq,
  output logic              ilvInitGo
);
  localparam logic [3:0] LAST_TAIL = 4'(TAIL_BITS - 1);

  phase_t            phase;
  logic [SIZE_W-1:0] sizeReg;
  logic [SIZE_W-1:0] addrNext;
  logic              punctReg;
  logic [1:0]        sub;
  logic [1:0]        lastSub;
  logic              inTail;
  logic [3:0]        tailCnt;

  assign inRdy    = (phase == PH_LOAD);
  assign outRdy   = (phase == PH_UNLOAD);
  assign ilvReq   = (phase == PH_ENCODE);
  assign addrNext = addr + 1'b1;
  assign lastSub  = punctReg ? 2'd1 : 2'd2;

  always_comb begin
    stb = '0;
    if (abortReq) begin
      stb.clear = 1'b1;
    end else begin
      unique case (phase)
        PH_LOAD:   stb.capture   = shiftInEn;
        PH_ENCODE: stb.encStep   = 1'b1;
        PH_TERM:   stb.termLatch = 1'b1;
        PH_UNLOAD: begin
          stb.emit     = shiftOutEn;
          stb.emitTail = inTail;
          stb.tailSel  = tailCnt;
          if (sub == 2'd0)   stb.emitSel = 2'd0;
          else if (punctReg) stb.emitSel = addr[0] ? 2'd2 : 2'd1;
          else               stb.emitSel = sub;
        end
        PH_FLUSH:  stb.clear = 1'b1;
        default:   stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_LOAD;
      addr      <= '0;
      sizeReg   <= '0;
      punctReg  <= 1'b0;
      sub       <= '0;
      inTail    <= 1'b0;
      tailCnt   <= '0;
      ilvInitGo <= 1'b0;
    end else begin
      ilvInitGo <= !abortReq && (phase == PH_LOAD) && ilvInitReq && (addr == '0);
      if (abortReq || phase == PH_FLUSH) begin
        phase    <= PH_LOAD;
        addr     <= '0;
        sizeReg  <= '0;
        punctReg <= 1'b0;
        sub      <= '0;
        inTail   <= 1'b0;
        tailCnt  <= '0;
      end else begin
        unique case (phase)
          PH_LOAD: if (shiftInEn) begin
            if (addrNext == blkSize) begin
              phase    <= PH_ENCODE;
              addr     <= '0;
              sizeReg  <= blkSize;
              punctReg <= punctureEn;
            end else begin
              addr <= addrNext;
            end
          end
          PH_ENCODE: begin
            if (addrNext == sizeReg) begin
              phase <= PH_TERM;
              addr  <= '0;
            end else begin
              addr <= addrNext;
            end
          end
          PH_TERM: phase <= PH_UNLOAD;
          PH_UNLOAD: if (shiftOutEn) begin
            if (inTail) begin
              if (tailCnt == LAST_TAIL) phase <= PH_FLUSH;
              else tailCnt <= tailCnt + 4'd1;
            end else if (sub == lastSub) begin
              sub <= '0;
              if (addrNext == sizeReg) inTail <= 1'b1;
              else addr <= addrNext;
            end else begin
              sub <= sub + 2'd1;
            end
          end
          default: phase <= PH_LOAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/turbo_enc_seq.sv
module turbo_enc_seq
  import turbo_seq_pkg::*;
#(
  parameter int MAX_BLK = 5114,
  parameter int SIZE_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abortReq,
  input  logic [SIZE_W-1:0] blkSize,
  input  logic              punctureEn,
  input  logic              ilvInitReq,
  input  logic              shiftInEn,
  input  logic              dataIn,
  input  logic              ilvBit,
  input  logic              shiftOutEn,
  output logic              inRdy,
  output logic              outRdy,
  output logic              dataOut,
  output logic              ilvReq,
  output logic [SIZE_W-1:0] ilvIdx,
  output logic              ilvInitGo
);
  seqStrobe_t        stb;
  logic [SIZE_W-1:0] addr;

  turbo_seq_ctl #(.SIZE_W(SIZE_W)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .abortReq  (abortReq),
    .blkSize   (blkSize),
    .punctureEn(punctureEn),
    .ilvInitReq(ilvInitReq),
    .shiftInEn (shiftInEn),
    .shiftOutEn(shiftOutEn),
    .stb       (stb),
    .addr      (addr),
    .inRdy     (inRdy),
    .outRdy    (outRdy),
    .ilvReq    (ilvReq),
    .ilvInitGo (ilvInitGo)
  );

  turbo_seq_dp #(.MAX_BLK(MAX_BLK), .SIZE_W(SIZE_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .addr   (addr),
    .dataIn (dataIn),
    .ilvBit (ilvBit),
    .dataOut(dataOut)
  );

  assign ilvIdx = addr;
endmodule

// File: rtl/turbo_enc_seq_chk.sv
module turbo_enc_seq_chk #(
  parameter int SIZE_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              abortReq,
  input logic              shiftOutEn,
  input logic              inRdy,
  input logic              outRdy,
  input logic              dataOut,
  input logic              ilvReq,
  input logic [SIZE_W-1:0] ilvIdx,
  input logic              ilvInitGo
);
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inRdy, outRdy, ilvReq})); // R2

  AST_ENTER_ENCODE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inRdy) |-> ilvReq && (ilvIdx == '0)); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ilvReq && $past(ilvReq) |-> ilvIdx == $past(ilvIdx) + 1'b1); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outRdy && !shiftOutEn && !abortReq |=> $stable(dataOut)); // R8

  AST_BACK_TO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outRdy) |=> inRdy && !dataOut); // R9

  AST_INIT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    ilvInitGo |-> $past(inRdy)); // R10

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> inRdy && !outRdy && !ilvReq && !dataOut); // R11
endmodule

bind turbo_enc_seq turbo_enc_seq_chk #(.SIZE_W(SIZE_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .abortReq  (abortReq),
  .shiftOutEn(shiftOutEn),
  .inRdy     (inRdy),
  .outRdy    (outRdy),
  .dataOut   (dataOut),
  .ilvReq    (ilvReq),
  .ilvIdx    (ilvIdx),
  .ilvInitGo (ilvInitGo)
);

// File: tb/sim_turbo_enc_seq.sv
module sim_turbo_enc_seq;
  localparam int SW   = 13;
  localparam int MAXN = 5114;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abortReq = 1'b0;
  logic [SW-1:0] blkSize = '0;
  logic punctureEn = 1'b0;
  logic ilvInitReq = 1'b0;
  logic shiftInEn = 1'b0;
  logic dataIn = 1'b0;
  logic ilvBit = 1'b0;
  logic shiftOutEn = 1'b0;
  logic inRdy, outRdy, dataOut, ilvReq, ilvInitGo;
  logic [SW-1:0] ilvIdx;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  bit xArr [MAXN];
  int perm [MAXN];
  bit expQ [$];
  int curN = 0;
  int seedV = 1;

  always #4 clk = ~clk;

  turbo_enc_seq u0 (
    .clk(clk), .rstN(rstN), .abortReq(abortReq), .blkSize(blkSize),
    .punctureEn(punctureEn), .ilvInitReq(ilvInitReq), .shiftInEn(shiftInEn),
    .dataIn(dataIn), .ilvBit(ilvBit), .shiftOutEn(shiftOutEn),
    .inRdy(inRdy), .outRdy(outRdy), .dataOut(dataOut), .ilvReq(ilvReq),
    .ilvIdx(ilvIdx), .ilvInitGo(ilvInitGo)
  );

  // external interleaver model: supplies the permuted bit for ilvIdx
  always @(negedge clk) begin
    if (ilvReq && int'(ilvIdx) < curN) ilvBit <= xArr[perm[int'(ilvIdx)]];
    else ilvBit <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit nextRand();
    seedV = (seedV * 1103515245 + 12345) & 32'h7fffffff;
    return seedV[16];
  endfunction

  // behavioural reference: fills expQ for an n-bit block
  task automatic buildRef(input int n, input bit punct);
    bit a1, a2, a3, b1, b2, b3, f, p1, p2;
    bit y1 [$];
    bit y2 [$];
    a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0;
    expQ.delete();
    for (int k = 0; k < n; k++) begin
      f = xArr[k] ^ a2 ^ a3; p1 = f ^ a1 ^ a3; a3 = a2; a2 = a1; a1 = f;
      f = xArr[perm[k]] ^ b2 ^ b3; p2 = f ^ b1 ^ b3; b3 = b2; b2 = b1; b1 = f;
      y1.push_back(p1); y2.push_back(p2);
    end
    for (int k = 0; k < n; k++) begin
      expQ.push_back(xArr[k]);
      if (!punct) begin
        expQ.push_back(y1[k]); expQ.push_back(y2[k]);
      end else begin
        expQ.push_back((k % 2 == 0) ? y1[k] : y2[k]);
      end
    end
    for (int t = 0; t < 3; t++) begin
      expQ.push_back(a2 ^ a3); expQ.push_back(a1 ^ a3);
      a3 = a2; a2 = a1; a1 = 0;
    end
    for (int t = 0; t < 3; t++) begin
      expQ.push_back(b2 ^ b3); expQ.push_back(b1 ^ b3);
      b3 = b2; b2 = b1; b1 = 0;
    end
  endtask

  // called at a negedge with inRdy high; returns at the first negedge of encoding
  task automatic loadBlock(input int n, input bit punct, input int inPause, input int extra);
    int i, j, stride;
    curN = n;
    stride = (n % 7 != 0) ? 7 : 11;
    for (int k = 0; k < n; k++) begin
      xArr[k] = nextRand();
      perm[k] = (k * stride) % n;
    end
    blkSize = SW'(n);
    punctureEn = punct;
    i = 0; j = 0;
    while (i < n) begin
      if (inPause > 0 && j % inPause == inPause - 1) begin
        shiftInEn = 1'b0; dataIn = nextRand();
      end else begin
        shiftInEn = 1'b1; dataIn = xArr[i]; i++;
      end
      j++;
      @(negedge clk);
    end
    // R12: change sampled controls once the block is full
    blkSize = SW'(n + 3);
    punctureEn = !punct;
    chk(inRdy == 1'b0, "R2 inRdy low after last bit", int'(inRdy), 0);
    chk(ilvReq == 1'b1 && ilvIdx == '0, "R2 encoding starts at index 0", int'(ilvIdx), 0);
  endtask

  // counts the encoding pass; extra bits are offered meanwhile (R3)
  task automatic runEncode(input int n, input int extra);
    int busy, reqs, badIdx, e;
    busy = 0; reqs = 0; badIdx = 0; e = 0;
    while (!outRdy && busy < n + 10) begin
      if (ilvReq) begin
        if (int'(ilvIdx) != reqs) badIdx++;
        reqs++;
      end
      busy++;
      if (e < extra) begin shiftInEn = 1'b1; dataIn = nextRand(); e++; end
      else shiftInEn = 1'b0;
      @(negedge clk);
    end
    shiftInEn = 1'b0;
    chk(busy == n + 1, "R2 busy cycles before outRdy", busy, n + 1);
    chk(reqs == n, "R2 ilvReq cycle count", reqs, n);
    chk(badIdx == 0, "R2 ilvIdx sequence errors", badIdx, 0);
  endtask

  // reads the whole coded stream; starts at a negedge with outRdy high
  task automatic unload(input int n, input bit punct, input int outPause);
    int i, j, total, dataBits, errs;
    bit prev;
    string tag;
    total = expQ.size();
    dataBits = punct ? 2 * n : 3 * n;
    chk(total == dataBits + 12, "R7 reference stream length", total, dataBits + 12);
    i = 0; j = 0; errs = 0;
    prev = dataOut;
    while (i < total) begin
      if (outPause > 0 && j % outPause == outPause - 1) begin
        shiftOutEn = 1'b0;
        @(negedge clk);
        chk(dataOut == prev, "R8 dataOut held while paused", int'(dataOut), int'(prev));
      end else begin
        shiftOutEn = 1'b1;
        @(negedge clk);
        tag = (i >= dataBits) ? "R7 tail bit" : (punct ? "R4/R6 punctured bit" : "R4/R5 full-rate bit");
        if (dataOut != expQ[i]) errs++;
        chk(dataOut == expQ[i], tag, int'(dataOut), int'(expQ[i]));
        prev = dataOut;
        i++;
      end
      j++;
    end
    shiftOutEn = 1'b0;
    chk(outRdy == 1'b0 && inRdy == 1'b0, "R9 outRdy low after last bit", int'(outRdy), 0);
    chk(dataOut == prev, "R9 last bit still visible", int'(dataOut), int'(prev));
    @(negedge clk);
    chk(inRdy == 1'b1 && dataOut == 1'b0, "R9 back to input, cleared", int'(inRdy), 1);
    chk(errs == 0, "R1 block round trip errors", errs, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        nFail++;
        nRun++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(inRdy == 1'b1 && outRdy == 1'b0 && ilvReq == 1'b0 && dataOut == 1'b0,
        "R11 state in reset", int'(inRdy), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R10: accepted at idle
    ilvInitReq = 1'b1;
    @(negedge clk);
    ilvInitReq = 1'b0;
    chk(ilvInitGo == 1'b1, "R10 init accepted at idle", int'(ilvInitGo), 1);
    @(negedge clk);
    chk(ilvInitGo == 1'b0, "R10 init pulse is one cycle", int'(ilvInitGo), 0);

    // full rate, block 40, paused input and output, extra bits offered (R1 R3 R5 R7 R8 R9)
    loadBlock(40, 1'b0, 5, 0);
    runEncode(40, 8);
    buildRef(40, 1'b0);
    unload(40, 1'b0, 4);

    // R10: refused once a bit is stored, accepted again after abort (R11)
    blkSize = SW'(40);
    shiftInEn = 1'b1; dataIn = 1'b1;
    @(negedge clk);
    shiftInEn = 1'b0; ilvInitReq = 1'b1;
    @(negedge clk);
    ilvInitReq = 1'b0;
    chk(ilvInitGo == 1'b0, "R10 init refused after first bit", int'(ilvInitGo), 0);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chk(inRdy == 1'b1 && outRdy == 1'b0, "R11 abort during input", int'(inRdy), 1);
    ilvInitReq = 1'b1;
    @(negedge clk);
    ilvInitReq = 1'b0;
    chk(ilvInitGo == 1'b1, "R10 init accepted after abort", int'(ilvInitGo), 1);
    @(negedge clk);

    // punctured block of odd length; controls flipped after load (R6 R7 R12)
    loadBlock(43, 1'b1, 0, 0);
    runEncode(43, 0);
    buildRef(43, 1'b1);
    unload(43, 1'b1, 3);

    // abort during the encoding pass (R11)
    loadBlock(41, 1'b0, 0, 0);
    repeat (5) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chk(inRdy == 1'b1 && ilvReq == 1'b0, "R11 abort during encoding", int'(ilvReq), 0);

    // abort during output (R11)
    loadBlock(40, 1'b0, 0, 0);
    runEncode(40, 0);
    buildRef(40, 1'b0);
    shiftOutEn = 1'b1;
    repeat (10) @(negedge clk);
    shiftOutEn = 1'b0;
    chk(dataOut == expQ[9], "R5 bit before abort", int'(dataOut), int'(expQ[9]));
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chk(inRdy == 1'b1 && outRdy == 1'b0 && dataOut == 1'b0, "R11 abort during output",
        int'(dataOut), 0);

    // a clean block after abort
    loadBlock(41, 1'b0, 0, 0);
    runEncode(41, 0);
    buildRef(41, 1'b0);
    unload(41, 1'b0, 0);

    // asynchronous reset in the middle of input (R11)
    blkSize = SW'(40);
    shiftInEn = 1'b1;
    repeat (5) @(negedge clk);
    shiftInEn = 1'b0;
    #1 rstN = 1'b0;
    #1 chk(inRdy == 1'b1 && dataOut == 1'b0, "R11 asynchronous reset", int'(inRdy), 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // largest block, punctured (R1 R2 R6 R7)
    loadBlock(5114, 1'b1, 0, 0);
    runEncode(5114, 0);
    buildRef(5114, 1'b1);
    unload(5114, 1'b1, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule